// File: doc/BRIEF.md
# Double-Buffered Process Data Exchange

This block is a shared dual-ported store through which a communication side and an application side swap cyclic process data. Each side owns a word-wide port that can read or write in every clock cycle, independent of the other side. Data flowing from the communication side to the application side (inbound) lives in one pair of pages. Data flowing the other way (outbound) lives in a second pair. A fifth page-sized area is a mailbox that both sides can read and write freely.

For each direction, a small flip controller keeps a view-page select bit and a pending flag. The producer always fills the page that is not currently visible. When it pulses its commit input, that page becomes the visible one, and the consumer's new-data flag rises. The consumer copies the visible page out at the start of its own cycle and then acknowledges, which clears the flag. If the producer commits again before the acknowledgement, the newer page replaces the older one and the flag stays set. Neither side ever waits on the other, and a reader never addresses a page that is being filled.

Each side addresses its port by a 2-bit region code and a word offset. Encodings: 00 is the mailbox, 01 is the side's own fill page, 10 is the latest page committed by the opposite side, and 11 is reserved. Both sides share one clock. Read data is registered and appears one cycle after the address is presented.

Top module: `pdx_exchange`

## Requirements
- R1: After reset both new-data flags are low and both read-data outputs are zero.
- R2: A word written in the mailbox (region 00) by either side is read back by the other side, with read data valid one cycle after the read request.
- R3: When both sides write the same mailbox word in the same cycle, the communication side's value is the one stored.
- R4: A commit pulse from the communication side raises the application-side new-data flag in the next cycle, and makes the page just filled (region 01 of the communication side) visible to the application side as region 10. Writes made after the commit go to the other page and do not change what the application side reads.
- R5: An application-side acknowledge clears its new-data flag in the next cycle, unless the communication side commits in the same cycle, in which case the flag stays set.
- R6: A second communication-side commit before acknowledgement makes the newer page visible to the application side and leaves the flag set. The page-select bit toggles on each commit and only on a commit.
- R7: The outbound direction behaves the same with the roles swapped. An application commit raises the communication-side flag and makes the application's fill page readable by the communication side as region 10. A communication acknowledge clears that flag.
- R8: Writes to region 10 or to region 11 are ignored. Reads of region 11 return zero.
- R9: A fill-page write presented in the same cycle as the commit pulse is part of the committed page.
- R10: A read and a write to the same word on one port in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c_en | input | 1 | Communication port access enable |
| c_we | input | 1 | Communication port write enable |
| c_region | input | 2 | Communication port region code |
| c_offset | input | 4 | Communication port word offset |
| c_wdata | input | 32 | Communication port write data |
| c_rdata | output | 32 | Communication port read data, one cycle after request |
| c_commit | input | 1 | Communication side publishes its inbound fill page |
| c_fresh | output | 1 | New outbound page available to the communication side |
| c_ack | input | 1 | Communication side has taken the outbound page |
| a_en | input | 1 | Application port access enable |
| a_we | input | 1 | Application port write enable |
| a_region | input | 2 | Application port region code |
| a_offset | input | 4 | Application port word offset |
| a_wdata | input | 32 | Application port write data |
| a_rdata | output | 32 | Application port read data, one cycle after request |
| a_commit | input | 1 | Application side publishes its outbound fill page |
| a_fresh | output | 1 | New inbound page available to the application side |
| a_ack | input | 1 | Application side has taken the inbound page |

## Verification
The flip logic is tried with four patterns:
- A single commit followed by an acknowledgement, which separates publishing from consuming.
- Two commits with no acknowledgement in between, which shows whether the newest page replaces the older one.
- A commit in the same cycle as an acknowledgement, which shows which of the two wins.
- A write in the same cycle as a commit, which shows whether the write lands on the committed page or the next one.

After each commit, the producer writes into its new fill page while the consumer rereads the visible page. This tells correct page isolation apart from a swapped select. The mailbox is tried with writes from each side, with simultaneous writes to one word, and with a read and a write to one word on the same port in the same cycle. These patterns expose the write priority and the read-first ordering.

// File: rtl/pdx_pkg.sv
package pdx_pkg;

    // Region code presented on each side's port
    typedef enum logic [1:0] {
        RGN_MBOX = 2'b00,
        RGN_FILL = 2'b01,
        RGN_VIEW = 2'b10,
        RGN_NONE = 2'b11
    } rgn_e;

    // Per-direction flip controller state
    typedef enum logic {
        FLIP_IDLE    = 1'b0,
        FLIP_PENDING = 1'b1
    } flip_st_e;

    // Page slot numbering inside the shared store
    localparam int SLOT_MBOX = 0;
    localparam int SLOT_IN   = 1;  // slots 1,2 : inbound pair
    localparam int SLOT_OUT  = 3;  // slots 3,4 : outbound pair
    localparam int SLOT_CNT  = 5;

endpackage

// File: rtl/pdx_flip_ctl.sv
module pdx_flip_ctl
    import pdx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic ack,
    output logic fresh,
    output logic view_sel
);

    flip_st_e state, state_nxt;
    logic     sel_q, sel_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FLIP_IDLE;
            sel_q <= 1'b0;
        end else begin
            state <= state_nxt;
            sel_q <= sel_nxt;
        end
    end

    // Transitions and outputs
    always_comb begin
        state_nxt = state;
        sel_nxt   = commit ? ~sel_q : sel_q;
        unique case (state)
            FLIP_IDLE: begin
                if (commit) state_nxt = FLIP_PENDING;       // PUBLISH
            end
            FLIP_PENDING: begin
                if (commit)   state_nxt = FLIP_PENDING;     // REPLACE
                else if (ack) state_nxt = FLIP_IDLE;        // CONSUME
            end
            default: state_nxt = FLIP_IDLE;
        endcase
        fresh    = (state == FLIP_PENDING);
        view_sel = sel_q;
    end

endmodule

// File: rtl/pdx_addr_xlat.sv
module pdx_addr_xlat
    import pdx_pkg::*;
#(
    parameter int PAGE_WORDS = 16,
    parameter int FILL_SLOT  = SLOT_IN,
    parameter int VIEW_SLOT  = SLOT_OUT,
    localparam int OFF_W     = $clog2(PAGE_WORDS),
    localparam int MEM_AW    = $clog2(SLOT_CNT * PAGE_WORDS)
) (
    input  logic              en,
    input  logic              we,
    input  logic [1:0]        region,
    input  logic [OFF_W-1:0]  offset,
    input  logic              fill_sel,
    input  logic              view_sel,
    output logic              mem_en,
    output logic              mem_we,
    output logic              mem_zero,
    output logic [MEM_AW-1:0] mem_addr
);

    rgn_e rgn;
    int   slot;

    always_comb begin
        rgn  = rgn_e'(region);
        slot = SLOT_MBOX;
        unique case (rgn)
            RGN_MBOX: slot = SLOT_MBOX;
            RGN_FILL: slot = FILL_SLOT + int'(fill_sel);
            RGN_VIEW: slot = VIEW_SLOT + int'(view_sel);
            RGN_NONE: slot = SLOT_MBOX;
            default:  slot = SLOT_MBOX;
        endcase
        mem_addr = MEM_AW'(slot * PAGE_WORDS + int'(offset));
        mem_en   = en;
        mem_zero = (rgn == RGN_NONE);
        mem_we   = en && we && ((rgn == RGN_MBOX) || (rgn == RGN_FILL));
    end

endmodule

// File: rtl/pdx_dpram.sv
module pdx_dpram #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 80,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p0_en,
    input  logic              p0_we,
    input  logic              p0_zero,
    input  logic [AW-1:0]     p0_addr,
    input  logic [DATA_W-1:0] p0_wdata,
    output logic [DATA_W-1:0] p0_rdata,
    input  logic              p1_en,
    input  logic              p1_we,
    input  logic              p1_zero,
    input  logic [AW-1:0]     p1_addr,
    input  logic [DATA_W-1:0] p1_wdata,
    output logic [DATA_W-1:0] p1_rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Port 0 is written last so it wins a same-word collision
    always_ff @(posedge clk) begin
        if (p1_we) mem[p1_addr] <= p1_wdata;
        if (p0_we) mem[p0_addr] <= p0_wdata;
    end

    // Registered, read-first outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p0_rdata <= '0;
            p1_rdata <= '0;
        end else begin
            if (p0_en) p0_rdata <= p0_zero ? '0 : mem[p0_addr];
            if (p1_en) p1_rdata <= p1_zero ? '0 : mem[p1_addr];
        end
    end

endmodule

// File: rtl/pdx_exchange.sv
module pdx_exchange
    import pdx_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int PAGE_WORDS = 16,
    localparam int OFF_W     = $clog2(PAGE_WORDS),
    localparam int DEPTH     = SLOT_CNT * PAGE_WORDS,
    localparam int MEM_AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c_en,
    input  logic              c_we,
    input  logic [1:0]        c_region,
    input  logic [OFF_W-1:0]  c_offset,
    input  logic [DATA_W-1:0] c_wdata,
    output logic [DATA_W-1:0] c_rdata,
    input  logic              c_commit,
    output logic              c_fresh,
    input  logic              c_ack,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [1:0]        a_region,
    input  logic [OFF_W-1:0]  a_offset,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              a_commit,
    output logic              a_fresh,
    input  logic              a_ack
);

    // Direction 0: inbound (comm -> app), direction 1: outbound (app -> comm)
    logic [1:0] dir_commit, dir_ack, dir_fresh, dir_sel;
    logic       in_sel, out_sel;

    assign dir_commit = {a_commit, c_commit};
    assign dir_ack    = {c_ack,    a_ack};

    for (genvar d = 0; d < 2; d++) begin : g_dir
        pdx_flip_ctl u_flip (
            .clk      (clk),
            .rst_n    (rst_n),
            .commit   (dir_commit[d]),
            .ack      (dir_ack[d]),
            .fresh    (dir_fresh[d]),
            .view_sel (dir_sel[d])
        );
    end

    assign in_sel  = dir_sel[0];
    assign out_sel = dir_sel[1];
    assign a_fresh = dir_fresh[0];
    assign c_fresh = dir_fresh[1];

    logic              cm_en, cm_we, cm_zero, am_en, am_we, am_zero;
    logic [MEM_AW-1:0] cm_addr, am_addr;

    pdx_addr_xlat #(
        .PAGE_WORDS (PAGE_WORDS),
        .FILL_SLOT  (SLOT_IN),
        .VIEW_SLOT  (SLOT_OUT)
    ) u_xlat_comm (
        .en       (c_en),
        .we       (c_we),
        .region   (c_region),
        .offset   (c_offset),
        .fill_sel (~in_sel),
        .view_sel (out_sel),
        .mem_en   (cm_en),
        .mem_we   (cm_we),
        .mem_zero (cm_zero),
        .mem_addr (cm_addr)
    );

    pdx_addr_xlat #(
        .PAGE_WORDS (PAGE_WORDS),
        .FILL_SLOT  (SLOT_OUT),
        .VIEW_SLOT  (SLOT_IN)
    ) u_xlat_app (
        .en       (a_en),
        .we       (a_we),
        .region   (a_region),
        .offset   (a_offset),
        .fill_sel (~out_sel),
        .view_sel (in_sel),
        .mem_en   (am_en),
        .mem_we   (am_we),
        .mem_zero (am_zero),
        .mem_addr (am_addr)
    );

    pdx_dpram #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .p0_en    (cm_en),
        .p0_we    (cm_we),
        .p0_zero  (cm_zero),
        .p0_addr  (cm_addr),
        .p0_wdata (c_wdata),
        .p0_rdata (c_rdata),
        .p1_en    (am_en),
        .p1_we    (am_we),
        .p1_zero  (am_zero),
        .p1_addr  (am_addr),
        .p1_wdata (a_wdata),
        .p1_rdata (a_rdata)
    );

endmodule

// File: rtl/pdx_exchange_chk.sv
module pdx_exchange_chk (
    input logic clk,
    input logic rst_n,
    input logic c_commit,
    input logic a_commit,
    input logic c_ack,
    input logic a_ack,
    input logic c_fresh,
    input logic a_fresh,
    input logic in_sel,
    input logic out_sel
);

    a_r4_publish: assert property (@(posedge clk) disable iff (!rst_n)
        c_commit |=> a_fresh);

    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_commit && !a_fresh) |=> !a_fresh);

    a_r5_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (a_fresh && a_ack && !c_commit) |=> !a_fresh);

    a_r6_flip: assert property (@(posedge clk) disable iff (!rst_n)
        c_commit |=> (in_sel != $past(in_sel)));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !c_commit |=> (in_sel == $past(in_sel)));

    a_r7_publish: assert property (@(posedge clk) disable iff (!rst_n)
        a_commit |=> c_fresh);

    a_r7_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (c_fresh && c_ack && !a_commit) |=> !c_fresh);

    a_r7_flip: assert property (@(posedge clk) disable iff (!rst_n)
        a_commit |=> (out_sel != $past(out_sel)));

endmodule

bind pdx_exchange pdx_exchange_chk u_chk (.*);

// File: tb/pdx_exchange_test.sv
module pdx_exchange_test;

    localparam int DW = 32;
    localparam int OW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          c_en = 0, c_we = 0, c_commit = 0, c_ack = 0;
    logic          a_en = 0, a_we = 0, a_commit = 0, a_ack = 0;
    logic [1:0]    c_region = 0, a_region = 0;
    logic [OW-1:0] c_offset = 0, a_offset = 0;
    logic [DW-1:0] c_wdata = 0, a_wdata = 0;
    logic [DW-1:0] c_rdata, a_rdata;
    logic          c_fresh, a_fresh;

    int errs   = 0;
    int checks = 0;

    always #2 clk = ~clk;   // 250 MHz

    pdx_exchange uut (
        .clk(clk), .rst_n(rst_n),
        .c_en(c_en), .c_we(c_we), .c_region(c_region), .c_offset(c_offset),
        .c_wdata(c_wdata), .c_rdata(c_rdata), .c_commit(c_commit),
        .c_fresh(c_fresh), .c_ack(c_ack),
        .a_en(a_en), .a_we(a_we), .a_region(a_region), .a_offset(a_offset),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_commit(a_commit),
        .a_fresh(a_fresh), .a_ack(a_ack)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_port(input bit app, input logic en, input logic we,
                            input logic [1:0] rg, input int off, input logic [DW-1:0] d);
        if (app) begin
            a_en = en; a_we = we; a_region = rg; a_offset = OW'(off); a_wdata = d;
        end else begin
            c_en = en; c_we = we; c_region = rg; c_offset = OW'(off); c_wdata = d;
        end
    endtask

    task automatic wr(input bit app, input logic [1:0] rg, input int off,
                      input logic [DW-1:0] d);
        @(negedge clk);
        set_port(app, 1'b1, 1'b1, rg, off, d);
        @(negedge clk);
        set_port(app, 1'b0, 1'b0, 2'b00, 0, '0);
    endtask

    task automatic rd(input bit app, input logic [1:0] rg, input int off,
                      output logic [DW-1:0] q);
        @(negedge clk);
        set_port(app, 1'b1, 1'b0, rg, off, '0);
        @(negedge clk);
        q = app ? a_rdata : c_rdata;
        set_port(app, 1'b0, 1'b0, 2'b00, 0, '0);
    endtask

    task automatic pulse(input bit cc, input bit ac, input bit ck, input bit ak);
        @(negedge clk);
        c_commit = cc; a_commit = ac; c_ack = ck; a_ack = ak;
        @(negedge clk);
        c_commit = 0; a_commit = 0; c_ack = 0; a_ack = 0;
    endtask

    task automatic t_reset();
        check(!a_fresh && !c_fresh, "R1 flags", {30'd0, a_fresh, c_fresh}, '0);
        check(c_rdata == '0 && a_rdata == '0, "R1 rdata", c_rdata | a_rdata, '0);
    endtask

    task automatic t_mailbox();
        logic [DW-1:0] q;
        wr(0, 2'b00, 4, 32'h0000_1234);
        rd(1, 2'b00, 4, q);
        check(q == 32'h1234, "R2 comm->app mailbox", q, 32'h1234);
        wr(1, 2'b00, 5, 32'h0000_5678);
        rd(0, 2'b00, 5, q);
        check(q == 32'h5678, "R2 app->comm mailbox", q, 32'h5678);
        @(negedge clk);
        set_port(0, 1, 1, 2'b00, 6, 32'hC0);
        set_port(1, 1, 1, 2'b00, 6, 32'hA0);
        @(negedge clk);
        set_port(0, 0, 0, 2'b00, 0, '0);
        set_port(1, 0, 0, 2'b00, 0, '0);
        rd(1, 2'b00, 6, q);
        check(q == 32'hC0, "R3 collision priority", q, 32'hC0);
    endtask

    task automatic t_read_first();
        logic [DW-1:0] q;
        wr(0, 2'b00, 7, 32'h1);
        @(negedge clk);
        set_port(0, 1, 1, 2'b00, 7, 32'h2);
        @(negedge clk);
        q = c_rdata;
        set_port(0, 0, 0, 2'b00, 0, '0);
        check(q == 32'h1, "R10 read-first", q, 32'h1);
        rd(0, 2'b00, 7, q);
        check(q == 32'h2, "R10 write landed", q, 32'h2);
    endtask

    task automatic t_publish();
        logic [DW-1:0] q;
        wr(0, 2'b01, 1, 32'hA1);
        pulse(1, 0, 0, 0);
        check(a_fresh == 1'b1, "R4 flag raised", {31'd0, a_fresh}, 1);
        rd(1, 2'b10, 1, q);
        check(q == 32'hA1, "R4 page visible", q, 32'hA1);
        wr(0, 2'b01, 1, 32'hB2);
        rd(1, 2'b10, 1, q);
        check(q == 32'hA1, "R4 fill isolated", q, 32'hA1);
        pulse(0, 0, 0, 1);
        check(a_fresh == 1'b0, "R5 ack clears", {31'd0, a_fresh}, 0);
    endtask

    task automatic t_replace();
        logic [DW-1:0] q;
        pulse(1, 0, 0, 0);                 // publishes B2 page
        wr(0, 2'b01, 1, 32'hC3);
        pulse(1, 0, 0, 0);                 // replaces with C3, no ack
        check(a_fresh == 1'b1, "R6 flag kept", {31'd0, a_fresh}, 1);
        rd(1, 2'b10, 1, q);
        check(q == 32'hC3, "R6 newest visible", q, 32'hC3);
        pulse(1, 0, 0, 1);                 // commit + ack in one cycle
        check(a_fresh == 1'b1, "R5 commit beats ack", {31'd0, a_fresh}, 1);
        rd(1, 2'b10, 1, q);
        check(q == 32'hB2, "R6 alternate page", q, 32'hB2);
        pulse(0, 0, 0, 1);
        check(a_fresh == 1'b0, "R5 final ack", {31'd0, a_fresh}, 0);
    endtask

    task automatic t_same_cycle();
        logic [DW-1:0] q;
        @(negedge clk);
        set_port(0, 1, 1, 2'b01, 3, 32'h55);
        c_commit = 1;
        @(negedge clk);
        set_port(0, 0, 0, 2'b00, 0, '0);
        c_commit = 0;
        rd(1, 2'b10, 3, q);
        check(q == 32'h55, "R9 write with commit", q, 32'h55);
        wr(1, 2'b10, 3, 32'hDEAD);
        rd(1, 2'b10, 3, q);
        check(q == 32'h55, "R8 view write ignored", q, 32'h55);
        pulse(0, 0, 0, 1);
    endtask

    task automatic t_reserved();
        logic [DW-1:0] q;
        wr(0, 2'b00, 0, 32'h11);
        wr(0, 2'b11, 0, 32'hBEEF);
        rd(0, 2'b11, 0, q);
        check(q == '0, "R8 reserved reads zero", q, '0);
        rd(0, 2'b00, 0, q);
        check(q == 32'h11, "R8 reserved write ignored", q, 32'h11);
    endtask

    task automatic t_outbound();
        logic [DW-1:0] q;
        wr(1, 2'b01, 0, 32'h77);
        pulse(0, 1, 0, 0);
        check(c_fresh == 1'b1, "R7 flag raised", {31'd0, c_fresh}, 1);
        rd(0, 2'b10, 0, q);
        check(q == 32'h77, "R7 page visible", q, 32'h77);
        wr(1, 2'b01, 0, 32'h88);
        rd(0, 2'b10, 0, q);
        check(q == 32'h77, "R7 fill isolated", q, 32'h77);
        pulse(0, 0, 1, 0);
        check(c_fresh == 1'b0, "R7 ack clears", {31'd0, c_fresh}, 0);
    endtask

    initial begin
        #(200000 * 4);
        errs++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_mailbox();
        t_read_first();
        t_publish();
        t_replace();
        t_same_cycle();
        t_reserved();
        t_outbound();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule